// File: doc/BRIEF.md
# Two-Wire Register File Slave with Auto-Increment Pointer

This block is a two-wire serial (I2C) target that gives a bus master byte access to a 64-entry on-chip register file. It oversamples SCL and SDA with the system clock. It detects START, repeated START and STOP conditions and shifts bits in and out on the SCL edges. The pad is outside the block. The block sees the bus level on `sda_i` and pulls the line low by raising `sda_drive_low_o`. The master never waits on the block, because the block does not stretch the clock.

A write transfer sets an internal address pointer from its first data byte. Each later byte is stored at the pointer, and the pointer then steps to the next location. A read transfer returns bytes from the pointer. There are two ways to read. A random read sets the pointer with a write header, then sends a repeated START and a read header. A current-address read sends a read header directly and continues from wherever the pointer was left. The pointer advances on a read only when the master acknowledges the byte, and it keeps its value from one transfer to the next.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The header byte after a START is sent MSB first and holds the 7-bit target address in bits 7..1 and R/W in bit 0 (1 = read). The block answers address 1101000 with an ACK, which means it holds SDA low through the 9th SCL pulse. For any other address it leaves SDA released for the rest of the transfer, including the ACK slots and the read data slots. It also writes nothing and leaves the pointer unchanged until the next START.
- R2: In a write transfer, the first byte after the header loads the pointer from its low 6 bits. The upper 2 bits are ignored.
- R3: Each byte after the pointer byte in a write transfer is stored at the pointer location, and the pointer then increments by one.
- R4: The block drives an ACK after a matching header, after the pointer byte and after every data byte it receives.
- R5: A write header, a pointer byte, a repeated START and a read header together make a random read. The first byte returned comes from the new pointer, sent MSB first.
- R6: During a read, the pointer increments only when the master ACKs a byte, and the next byte then comes from the incremented address. A byte that the master NACKs leaves the pointer unchanged.
- R7: A read header that follows a START with no pointer write returns first the byte at the pointer value left by the previous transfer.
- R8: After the master NACKs a read byte, the block keeps SDA released for any further SCL pulses until a START or STOP.
- R9: The pointer wraps from location 63 to location 0, on both writes and acknowledged reads.
- R10: After reset, SDA is released, the pointer is 0 and all 64 registers read as 0x00.
- R11: A STOP aborts any transfer in progress. A data byte that is cut short by a STOP is not stored. The next START is recognised normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock level from the pad |
| sda_i | input | 1 | Serial data level from the pad |
| sda_drive_low_o | output | 1 | 1 pulls the SDA pad low; 0 releases it |

## Verification
The hardest states to reach are the ones in which the block must stay silent or keep its pointer while the bus keeps running. One is a NACKed read byte followed by extra clock pulses with no STOP. Another is a header for a foreign address followed by data bytes and read slots. A third is a STOP in the middle of a data byte. The bench master drives each of these bus sequences bit by bit. It then proves that nothing changed by reading the pointer and the registers back through ordinary random and current-address reads. It also samples the wired-AND line in every ACK and data slot. The pointer wrap is reached by loading the pointer with 63, and the retained pointer by chaining current-address reads after NACKed bytes.

// File: rtl/i2cr_pkg.sv
`timescale 1ns/1ps
package i2cr_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEVADR,
      ST_PTR,
      ST_WDATA,
      ST_ACK,
      ST_TX,
      ST_RACK,
      ST_WAIT
   } state_t;

endpackage

// File: rtl/i2cr_sync.sv
`timescale 1ns/1ps
module i2cr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2cr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_prev, sda_prev;
   logic              scl_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff   <= '1;
         sda_ff   <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
         scl_prev <= scl_ff[STAGES-1];
         sda_prev <= sda_ff[STAGES-1];
      end
   end

   assign scl_now   = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_now & ~scl_prev;
   assign scl_fall  = ~scl_now & scl_prev;
   assign start_det = scl_now & scl_prev & sda_prev & ~sda_s;
   assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/i2cr_regfile.sv
`timescale 1ns/1ps
module i2cr_regfile #(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 8,
   parameter bit RESET_MEM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("i2cr_regfile: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("i2cr_regfile: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];

   if (RESET_MEM) begin : g_reset_mem
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
         end
      end
   end else begin : g_plain_mem
      always_ff @(posedge clk) begin
         if (wr_en) mem_q[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem_q[rd_addr];

   // R3: a strobed write is visible at its location one cycle later
   assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/i2cr_engine.sv
`timescale 1ns/1ps
module i2cr_engine
   import i2cr_pkg::*;
#(
   parameter int          ADDR_W     = 6,
   parameter logic [6:0]  SLAVE_ADDR = 7'h68
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              sda_drive_low_o
);

   if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_ptr
      $error("i2cr_engine: ADDR_W must fit in one byte");
   end

   localparam logic [3:0] BITS_PER_BYTE = 4'(BYTE_W);
   localparam logic [3:0] LAST_TX_BIT   = 4'(BYTE_W - 1);

   state_t              state_q, state_d;
   state_t              ack_nxt_q, ack_nxt_d;
   logic [3:0]          cnt_q, cnt_d;
   logic [BYTE_W-1:0]   shr_q, shr_d;
   logic [BYTE_W-1:0]   tx_q, tx_d;
   logic [ADDR_W-1:0]   ptr_q, ptr_d;
   logic                mack_q, mack_d;
   logic                sda_q, sda_d;
   logic                ptr_load, ptr_inc;

   always_comb begin
      state_d   = state_q;
      ack_nxt_d = ack_nxt_q;
      cnt_d     = cnt_q;
      shr_d     = shr_q;
      tx_d      = tx_q;
      mack_d    = mack_q;
      ptr_load  = 1'b0;
      ptr_inc   = 1'b0;
      wr_en     = 1'b0;
      if (start_det) begin
         state_d = ST_DEVADR;
         cnt_d   = '0;
      end else if (stop_det) begin
         state_d = ST_IDLE;
         cnt_d   = '0;
      end else begin
         case (state_q)
            ST_DEVADR, ST_PTR, ST_WDATA: begin
               if (scl_rise && cnt_q < BITS_PER_BYTE) begin
                  shr_d = {shr_q[BYTE_W-2:0], sda_s};
                  cnt_d = cnt_q + 1'b1;
               end else if (scl_fall && cnt_q == BITS_PER_BYTE) begin
                  cnt_d = '0;
                  if (state_q == ST_DEVADR) begin
                     if (shr_q[BYTE_W-1:1] == SLAVE_ADDR) begin
                        state_d   = ST_ACK;
                        ack_nxt_d = shr_q[0] ? ST_TX : ST_PTR;
                     end else begin
                        state_d = ST_WAIT;
                     end
                  end else if (state_q == ST_PTR) begin
                     ptr_load  = 1'b1;
                     state_d   = ST_ACK;
                     ack_nxt_d = ST_WDATA;
                  end else begin
                     wr_en     = 1'b1;
                     ptr_inc   = 1'b1;
                     state_d   = ST_ACK;
                     ack_nxt_d = ST_WDATA;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  state_d = ack_nxt_q;
                  cnt_d   = '0;
                  if (ack_nxt_q == ST_TX) tx_d = rd_data;
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (cnt_q == LAST_TX_BIT) begin
                     state_d = ST_RACK;
                     cnt_d   = '0;
                  end else begin
                     tx_d  = {tx_q[BYTE_W-2:0], 1'b1};
                     cnt_d = cnt_q + 1'b1;
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) mack_d = ~sda_s;
               if (scl_fall) begin
                  if (mack_q) begin
                     ptr_inc = 1'b1;
                     tx_d    = rd_data;
                     state_d = ST_TX;
                     cnt_d   = '0;
                  end else begin
                     state_d = ST_WAIT;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      if (ptr_load)     ptr_d = shr_q[ADDR_W-1:0];
      else if (ptr_inc) ptr_d = ptr_q + 1'b1;
      else              ptr_d = ptr_q;
   end

   assign rd_addr = (state_q == ST_RACK) ? ptr_q + 1'b1 : ptr_q;
   assign wr_addr = ptr_q;
   assign wr_data = shr_q;
   assign sda_d   = (state_q == ST_ACK) | ((state_q == ST_TX) & ~tx_q[BYTE_W-1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         ack_nxt_q <= ST_IDLE;
         cnt_q     <= '0;
         shr_q     <= '0;
         tx_q      <= '1;
         ptr_q     <= '0;
         mack_q    <= 1'b0;
         sda_q     <= 1'b0;
      end else begin
         state_q   <= state_d;
         ack_nxt_q <= ack_nxt_d;
         cnt_q     <= cnt_d;
         shr_q     <= shr_d;
         tx_q      <= tx_d;
         ptr_q     <= ptr_d;
         mack_q    <= mack_d;
         sda_q     <= sda_d;
      end
   end

   assign sda_drive_low_o = sda_q;

   // R11: a START always leads into header reception
   assert_start_to_header_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> state_q == ST_DEVADR);

   // R11: a STOP always returns the engine to idle
   assert_stop_to_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_det && !start_det) |=> state_q == ST_IDLE);

   // R1 R8: silent states never pull the line once they have settled
   assert_release_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_IDLE || state_q == ST_WAIT) &&
       ($past(state_q) == ST_IDLE || $past(state_q) == ST_WAIT)) |-> !sda_drive_low_o);

   // R3 R6: the pointer moves only by a load or a single step
   assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q != $past(ptr_q)) |-> ($past(ptr_load) || ADDR_W'(ptr_q - $past(ptr_q)) == ADDR_W'(1)));

   // R6: a NACKed read byte leaves the pointer where it was
   assert_nack_holds_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RACK && scl_fall && !mack_q && !start_det && !stop_det) |=> $stable(ptr_q));

   // R9: stepping past the last location lands on location zero
   assert_ptr_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ptr_q) == '1 && !$past(ptr_load) && ptr_q != $past(ptr_q)) |-> ptr_q == '0);

endmodule

// File: rtl/i2c_regfile_slave.sv
`timescale 1ns/1ps
module i2c_regfile_slave #(
   parameter logic [6:0] SLAVE_ADDR  = 7'h68,
   parameter int         ADDR_W      = 6,
   parameter int         SYNC_STAGES = 2,
   parameter bit         RESET_MEM   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_drive_low_o
);

   import i2cr_pkg::*;

   logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic              wr_en;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [BYTE_W-1:0] rd_data, wr_data;

   i2cr_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2cr_engine #(.ADDR_W(ADDR_W), .SLAVE_ADDR(SLAVE_ADDR)) engine_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .sda_s           (sda_s),
      .scl_rise        (scl_rise),
      .scl_fall        (scl_fall),
      .start_det       (start_det),
      .stop_det        (stop_det),
      .rd_data         (rd_data),
      .rd_addr         (rd_addr),
      .wr_en           (wr_en),
      .wr_addr         (wr_addr),
      .wr_data         (wr_data),
      .sda_drive_low_o (sda_drive_low_o)
   );

   i2cr_regfile #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W), .RESET_MEM(RESET_MEM)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

endmodule

// File: tb/i2c_regfile_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_regfile_slave_tb_top;

   localparam int QT = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic mst_low = 1'b0;
   logic dut_low;
   logic sda_line;

   always #2 clk = ~clk;

   assign sda_line = ~(mst_low | dut_low);

   i2c_regfile_slave dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .scl_i           (scl),
      .sda_i           (sda_line),
      .sda_drive_low_o (dut_low)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [7:0] exp_val[$];
   string      exp_tag[$];
   logic [7:0] got_byte;
   event       got_ev;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // monitor: pops the expected byte for every byte the master captures
   always @(got_ev) begin
      if (exp_val.size() == 0) begin
         check(1'b0, "scoreboard underflow", int'(got_byte), 0);
      end else begin
         logic [7:0] e;
         string t;
         e = exp_val.pop_front();
         t = exp_tag.pop_front();
         check(got_byte == e, t, int'(got_byte), int'(e));
      end
   end

   task automatic clk_bit(input bit b, output bit s);
      #QT mst_low = ~b;
      #QT scl = 1'b1;
      #QT s = sda_line;
      #QT scl = 1'b0;
   endtask

   task automatic bus_start();
      #QT mst_low = 1'b0;
      #QT scl = 1'b1;
      #(2*QT) mst_low = 1'b1;
      #(2*QT) scl = 1'b0;
   endtask

   task automatic bus_stop();
      #QT mst_low = 1'b1;
      #QT scl = 1'b1;
      #(2*QT) mst_low = 1'b0;
      #(2*QT);
   endtask

   // sends a byte; exp_nack 0 means an ACK from the block is expected
   task automatic tx_byte(input logic [7:0] b, input bit exp_nack, input string tag);
      bit s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
      clk_bit(1'b1, s);
      check(s == exp_nack, tag, int'(s), int'(exp_nack));
   endtask

   // driver side: pushes the expected byte, then clocks it and answers ack
   task automatic rx_byte(input bit give_ack, input logic [7:0] exp, input string tag);
      bit s;
      logic [7:0] v;
      exp_val.push_back(exp);
      exp_tag.push_back(tag);
      v = '0;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         v[i] = s;
      end
      got_byte = v;
      -> got_ev;
      clk_bit(~give_ack, s);
      mst_low = 1'b0;
   endtask

   task automatic set_ptr_rstart(input logic [7:0] p, input string tag);
      bus_start();
      tx_byte(8'hD0, 1'b0, tag);
      tx_byte(p, 1'b0, tag);
      bus_start();
      tx_byte(8'hD1, 1'b0, tag);
   endtask

   initial begin
      bit s;
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      #100;
      check(dut_low == 1'b0, "R10 SDA released after reset", int'(dut_low), 0);

      // R10 R7: current-address read right after reset, pointer 0
      bus_start();
      tx_byte(8'hD1, 1'b0, "R7 read header ack");
      rx_byte(1'b0, 8'h00, "R10 register 0 cleared");
      bus_stop();

      // R2 R3 R4: pointer write then three data bytes
      bus_start();
      tx_byte(8'hD0, 1'b0, "R4 header ack");
      tx_byte(8'h10, 1'b0, "R4 pointer ack");
      tx_byte(8'h11, 1'b0, "R3 data ack 0");
      tx_byte(8'h22, 1'b0, "R3 data ack 1");
      tx_byte(8'h33, 1'b0, "R3 data ack 2");
      bus_stop();

      // R5 R6: random read with sequential bytes
      set_ptr_rstart(8'h10, "R5 random read header");
      rx_byte(1'b1, 8'h11, "R5 first byte at pointer");
      rx_byte(1'b1, 8'h22, "R6 next byte after ack");
      rx_byte(1'b0, 8'h33, "R6 third byte");
      bus_stop();

      // R7 R6: current-address reads reuse pointer 0x12, NACK keeps it
      bus_start();
      tx_byte(8'hD1, 1'b0, "R7 header ack");
      rx_byte(1'b0, 8'h33, "R7 current address read");
      bus_stop();
      bus_start();
      tx_byte(8'hD1, 1'b0, "R7 header ack again");
      rx_byte(1'b0, 8'h33, "R6 NACK kept pointer");
      bus_stop();

      // R2: upper pointer bits ignored (0xC5 -> location 5)
      bus_start();
      tx_byte(8'hD0, 1'b0, "R2 header");
      tx_byte(8'hC5, 1'b0, "R2 pointer ack");
      tx_byte(8'h77, 1'b0, "R3 data ack");
      bus_stop();
      set_ptr_rstart(8'h05, "R2 readback header");
      rx_byte(1'b0, 8'h77, "R2 low six bits used");
      bus_stop();

      // R9: wrap on write and on read
      bus_start();
      tx_byte(8'hD0, 1'b0, "R9 header");
      tx_byte(8'h3F, 1'b0, "R9 pointer ack");
      tx_byte(8'hA5, 1'b0, "R9 data at 63");
      tx_byte(8'h5A, 1'b0, "R9 data at 0");
      bus_stop();
      set_ptr_rstart(8'h3F, "R9 readback header");
      rx_byte(1'b1, 8'hA5, "R9 location 63");
      rx_byte(1'b0, 8'h5A, "R9 read wrapped to 0");
      bus_stop();
      bus_start();
      tx_byte(8'hD1, 1'b0, "R9 header");
      rx_byte(1'b0, 8'h5A, "R9 pointer sits at 0");
      bus_stop();

      // R1: foreign addresses ignored, both directions
      bus_start();
      tx_byte(8'hA0, 1'b1, "R1 foreign header NACK");
      tx_byte(8'h10, 1'b1, "R1 no ack to pointer");
      tx_byte(8'hEE, 1'b1, "R1 no ack to data");
      bus_stop();
      bus_start();
      tx_byte(8'hD3, 1'b1, "R1 near-miss read header NACK");
      rx_byte(1'b0, 8'hFF, "R1 no data driven");
      bus_stop();
      bus_start();
      tx_byte(8'hD1, 1'b0, "R1 header");
      rx_byte(1'b0, 8'h5A, "R1 pointer untouched");
      bus_stop();
      set_ptr_rstart(8'h10, "R1 readback header");
      rx_byte(1'b0, 8'h11, "R1 register untouched");
      // R8: further clocks after NACK without STOP
      rx_byte(1'b0, 8'hFF, "R8 SDA released after NACK");
      bus_stop();

      // R11: STOP inside a data byte discards it
      bus_start();
      tx_byte(8'hD0, 1'b0, "R11 header");
      tx_byte(8'h20, 1'b0, "R11 pointer ack");
      for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
      bus_stop();
      set_ptr_rstart(8'h20, "R11 next START recognised");
      rx_byte(1'b0, 8'h00, "R11 partial byte not stored");
      bus_stop();

      #400;
      check(exp_val.size() == 0, "scoreboard drained", exp_val.size(), 0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #700000;
      if (!finished) begin
         check(1'b0, "watchdog expired", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule